// File: doc/BRIEF.md
# Windowed Energy Presence Detector

This block watches a stream of complex baseband samples, signed in-phase and quadrature words, and decides whether a signal is present. For every accepted sample it computes the instantaneous energy, the sum of the two squared components, and marks the sample as qualifying when that energy reaches a per-sample energy threshold. It keeps the qualify marks of the most recent accepted samples in an addressable shift register, so the window length can be chosen at run time. It asserts a level `detect` output when the number of qualifying samples inside a full window is larger than a count threshold. The `detect` level is meant to enable a downstream correlation stage, which stays idle while no signal is present.

The sample input uses a valid/ready handshake. A sample is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low during reset. It is also low in any cycle where a configuration input differs from the value held since the previous edge. A sender must keep its sample stable until it is taken. The block never stalls for any other reason.

Top module: `energy_presence_detector`

## Requirements
- R1: The energy of a sample is I*I + Q*Q, with I and Q as two's-complement numbers. The sample qualifies when its energy is greater than or equal to `cfg_energy_thr`. This holds for the most negative input code.
- R2: The effective window length L is `cfg_win_len`, with 0 treated as 1 and any value above 64 treated as 64.
- R3: The qualify count covers the last L samples accepted since the window was last cleared. It is updated incrementally: the newest mark is added, and the mark L samples back is subtracted once the window is full.
- R4: `detect` is high only when at least L samples have been accepted since the last clear and the qualify count is strictly greater than `cfg_count_thr`.
- R5: `detect` is a register. It changes only on the edge that accepts a sample or on a clearing edge, and it holds its value while no sample is accepted.
- R6: On any edge where one of `cfg_win_len`, `cfg_energy_thr` or `cfg_count_thr` differs from its value at the previous edge, the window and the count are emptied and `detect` goes low. In that cycle `in_ready` is low and no sample is taken.
- R7: `in_ready` is low while `rst_n` is low. Outside reset it is high except in the cycles described in R6.
- R8: After reset `detect` is low and the window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample word is valid |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_i | input | SAMPLE_W | In-phase sample, signed |
| in_q | input | SAMPLE_W | Quadrature sample, signed |
| cfg_win_len | input | LEN_W | Requested window length |
| cfg_energy_thr | input | 2*SAMPLE_W | Per-sample energy threshold, unsigned |
| cfg_count_thr | input | LEN_W | Qualify count that must be exceeded |
| detect | output | 1 | Signal-present level, correlator enable |

## Verification
The assertions assume that the configuration inputs change only between clock edges and then stay put. On an edge where a setting has just moved, the window-full and count checks are masked, because `detect` still reflects the old settings until the clear lands. The stimulus changes a setting only from a task that leaves at least one cycle before the next sample. It drives every input two nanoseconds after the rising edge and keeps a sample on the port until `in_ready` has been seen high.

// File: rtl/ped_pkg.sv
`timescale 1ns/1ps
package ped_pkg;
  // Maps a requested window length onto the legal range 1..max_len.
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned max_len);
    if (req == 0) return 1;
    else if (req > max_len) return max_len;
    else return req;
  endfunction
endpackage

// File: rtl/ped_energy.sv
`timescale 1ns/1ps
module ped_energy #(
  parameter int SAMPLE_W = 12,
  localparam int ENERGY_W = 2 * SAMPLE_W
) (
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  input  logic        [ENERGY_W-1:0] thr,
  output logic        [ENERGY_W-1:0] energy,
  output logic                       qual
);
  logic signed [ENERGY_W-1:0] sq_i, sq_q;

  // Both squares are non-negative and their sum fits in 2*SAMPLE_W bits.
  assign sq_i   = ENERGY_W'(in_i) * ENERGY_W'(in_i);
  assign sq_q   = ENERGY_W'(in_q) * ENERGY_W'(in_q);
  assign energy = $unsigned(sq_i) + $unsigned(sq_q);
  assign qual   = (energy >= thr);
endmodule

// File: rtl/ped_window.sv
`timescale 1ns/1ps
module ped_window #(
  parameter int MAX_WIN = 64,
  parameter int LEN_W   = $clog2(MAX_WIN + 1),
  localparam int IDX_W  = $clog2(MAX_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             bit_in,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] count_nxt,
  output logic [LEN_W-1:0] fill_nxt,
  output logic [LEN_W-1:0] count,
  output logic [LEN_W-1:0] fill
);
  logic [MAX_WIN-1:0] marks;
  logic [IDX_W-1:0]   tap;
  logic               leaving;
  logic               full;

  // The addressable tap picks the mark that drops out of a window of length len.
  assign tap     = IDX_W'(len - LEN_W'(1));
  assign leaving = marks[tap];
  assign full    = (fill == len);

  always_comb begin
    count_nxt = count;
    fill_nxt  = fill;
    if (clear) begin
      count_nxt = '0;
      fill_nxt  = '0;
    end else if (push) begin
      if (full) begin
        count_nxt = count + LEN_W'(bit_in) - LEN_W'(leaving);
      end else begin
        fill_nxt  = fill + LEN_W'(1);
        count_nxt = count + LEN_W'(bit_in);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      fill  <= '0;
    end else begin
      count <= count_nxt;
      fill  <= fill_nxt;
    end
  end

  // One stage per window slot; stage 0 takes the newest mark.
  for (genvar g = 0; g < MAX_WIN; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        marks[g] <= 1'b0;
      end else if (push && !clear) begin
        if (g == 0) marks[g] <= bit_in;
        else        marks[g] <= marks[(g == 0) ? 0 : g - 1];
      end
    end
  end
endmodule

// File: rtl/ped_decide.sv
`timescale 1ns/1ps
module ped_decide #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] count_thr,
  input  logic [LEN_W-1:0] count_nxt,
  input  logic [LEN_W-1:0] fill_nxt,
  output logic             detect
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      detect <= 1'b0;
    end else if (clear) begin
      detect <= 1'b0;
    end else if (push) begin
      detect <= (fill_nxt == len) && (count_nxt > count_thr);
    end
  end
endmodule

// File: rtl/energy_presence_detector.sv
`timescale 1ns/1ps
module energy_presence_detector #(
  parameter int SAMPLE_W = 12,
  parameter int MAX_WIN  = 64,
  localparam int LEN_W    = $clog2(MAX_WIN + 1),
  localparam int ENERGY_W = 2 * SAMPLE_W,
  localparam int CFG_W    = 2 * LEN_W + ENERGY_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  input  logic        [LEN_W-1:0]    cfg_win_len,
  input  logic        [ENERGY_W-1:0] cfg_energy_thr,
  input  logic        [LEN_W-1:0]    cfg_count_thr,
  output logic                       detect
);
  logic [CFG_W-1:0]    cfg_now, cfg_held;
  logic                cfg_moved;
  logic                alive;
  logic                accept;
  logic [LEN_W-1:0]    eff_len;
  logic [ENERGY_W-1:0] energy;
  logic                qual;
  logic [LEN_W-1:0]    win_count, win_fill, count_nxt, fill_nxt;

  assign cfg_now   = {cfg_win_len, cfg_energy_thr, cfg_count_thr};
  assign cfg_moved = (cfg_now != cfg_held);
  assign eff_len   = LEN_W'(ped_pkg::clamp_len(32'(cfg_win_len), MAX_WIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_held <= '0;
      alive    <= 1'b0;
    end else begin
      cfg_held <= cfg_now;
      alive    <= 1'b1;
    end
  end

  assign in_ready = alive && !cfg_moved;
  assign accept   = in_valid && in_ready;

  ped_energy #(.SAMPLE_W(SAMPLE_W)) u_energy (
    .in_i   (in_i),
    .in_q   (in_q),
    .thr    (cfg_energy_thr),
    .energy (energy),
    .qual   (qual)
  );

  ped_window #(.MAX_WIN(MAX_WIN), .LEN_W(LEN_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cfg_moved),
    .push      (accept),
    .bit_in    (qual),
    .len       (eff_len),
    .count_nxt (count_nxt),
    .fill_nxt  (fill_nxt),
    .count     (win_count),
    .fill      (win_fill)
  );

  ped_decide #(.LEN_W(LEN_W)) u_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cfg_moved),
    .push      (accept),
    .len       (eff_len),
    .count_thr (cfg_count_thr),
    .count_nxt (count_nxt),
    .fill_nxt  (fill_nxt),
    .detect    (detect)
  );
endmodule

// File: rtl/ped_checker.sv
`timescale 1ns/1ps
module ped_checker #(
  parameter int LEN_W    = 7,
  parameter int ENERGY_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LEN_W-1:0]    cfg_win_len,
  input logic [ENERGY_W-1:0] cfg_energy_thr,
  input logic [LEN_W-1:0]    cfg_count_thr,
  input logic                detect,
  input logic [LEN_W-1:0]    fill,
  input logic [LEN_W-1:0]    count,
  input logic [LEN_W-1:0]    eff_len
);
  logic cfg_still;
  assign cfg_still = 1'b1;

  // R6: a settings change empties the window and drops detect on that edge.
  p_clear_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg_win_len) || !$stable(cfg_energy_thr) || !$stable(cfg_count_thr))
    |=> (!detect && fill == '0 && count == '0));

  // R7: no sample is taken while a settings change is pending.
  p_ready_low_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg_win_len) || !$stable(cfg_energy_thr) || !$stable(cfg_count_thr))
    |-> !in_ready);

  // R4: detect only with a full window and a count above the threshold.
  p_detect_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && $stable(cfg_win_len) && $stable(cfg_count_thr) && $stable(cfg_energy_thr))
    |-> (fill == eff_len && count > cfg_count_thr));

  // R3: the count never exceeds the fill, and the fill never exceeds the window.
  p_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cfg_win_len) && cfg_still) |-> (count <= fill && fill <= eff_len));

  // R5: with no accepted sample and no settings change, state holds.
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && $stable(cfg_win_len) && $stable(cfg_energy_thr)
     && $stable(cfg_count_thr))
    |=> ($stable(detect) && $stable(count) && $stable(fill)));
endmodule

bind energy_presence_detector ped_checker #(.LEN_W(LEN_W), .ENERGY_W(ENERGY_W)) u_ped_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .cfg_win_len    (cfg_win_len),
  .cfg_energy_thr (cfg_energy_thr),
  .cfg_count_thr  (cfg_count_thr),
  .detect         (detect),
  .fill           (win_fill),
  .count          (win_count),
  .eff_len        (eff_len)
);

// File: tb/test_energy_presence_detector.sv
`timescale 1ns/1ps
module test_energy_presence_detector;
  localparam int SW = 12;
  localparam int MW = 64;
  localparam int LW = 7;
  localparam int EW = 24;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [SW-1:0] in_i = '0;
  logic signed [SW-1:0] in_q = '0;
  logic [LW-1:0]        cfg_win_len = 7'd8;
  logic [EW-1:0]        cfg_energy_thr = 24'd100;
  logic [LW-1:0]        cfg_count_thr = 7'd3;
  logic                 detect;

  int tests = 0;
  int fails = 0;

  // Reference model state
  int    hist_q[$];
  int    m_len = 8;
  int    m_ethr = 100;
  int    m_cthr = 3;
  bit    last_exp = 1'b0;
  bit    exp_q[$];
  string tag_q[$];
  bit    pend = 1'b0;

  always #4 clk = ~clk;

  energy_presence_detector i_energy_presence_detector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .cfg_win_len(cfg_win_len),
    .cfg_energy_thr(cfg_energy_thr), .cfg_count_thr(cfg_count_thr), .detect(detect)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp(input int v);
    if (v == 0) return 1;
    if (v > MW) return MW;
    return v;
  endfunction

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // Driver: computes the expected detect level from the requirements and queues it.
  task automatic send(input int si, input int sq, input string tag);
    int  e;
    int  cnt;
    e   = si * si + sq * sq;
    cnt = 0;
    hist_q.push_front((e >= m_ethr) ? 1 : 0);
    if (hist_q.size() > MW) void'(hist_q.pop_back());
    if (hist_q.size() >= m_len)
      for (int k = 0; k < m_len; k++) cnt += hist_q[k];
    last_exp = (hist_q.size() >= m_len) && (cnt > m_cthr);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    in_i = SW'(si);
    in_q = SW'(sq);
    in_valid = 1'b1;
    while (!in_ready) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic set_cfg(input int len, input int ethr, input int cthr);
    cfg_win_len    = LW'(len);
    cfg_energy_thr = EW'(ethr);
    cfg_count_thr  = LW'(cthr);
    m_len  = clamp(len);
    m_ethr = ethr;
    m_cthr = cthr;
    hist_q.delete();
    last_exp = 1'b0;
    #1;
    check(in_ready == 1'b0, "R6 ready low on change", int'(in_ready), 0);
    @(posedge clk); #2;
    check(in_ready == 1'b1, "R7 ready back after change", int'(in_ready), 1);
    check(detect == 1'b0, "R6 detect cleared", int'(detect), 0);
  endtask

  // Monitor: compares detect one edge after each accepted sample.
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "scoreboard underflow", 0, 1);
        end else begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(detect == e, t, int'(detect), int'(e));
        end
      end
      pend = rst_n && in_valid && in_ready;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(detect == 1'b0, "R8 detect low in reset", int'(detect), 0);
    check(in_ready == 1'b0, "R7 ready low in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    idle(2);
    check(in_ready == 1'b1, "R7 ready high after reset", int'(in_ready), 1);
    check(detect == 1'b0, "R8 detect low after reset", int'(detect), 0);

    // R1: threshold boundary and signed inputs, window of one
    set_cfg(1, 100, 0);
    send(6, 8, "R1 energy equal to threshold");
    send(6, 7, "R1 energy below threshold");
    send(-6, -8, "R1 negative components");
    send(0, -10, "R1 quadrature only");
    send(0, 0, "R1 zero sample");

    // R3/R4: window of eight, count must exceed three
    set_cfg(8, 100, 3);
    for (int k = 0; k < 8; k++) send(10, 0, "R4 fill then detect");
    idle(5);
    check(detect == last_exp, "R5 hold while idle", int'(detect), int'(last_exp));
    for (int k = 0; k < 5; k++) send(1, 1, "R3 count decays");
    idle(3);
    check(detect == last_exp, "R5 hold low while idle", int'(detect), int'(last_exp));

    // R2: length clamping
    set_cfg(0, 1, 0);
    send(1, 0, "R2 zero length acts as one");
    send(0, 0, "R2 zero length acts as one");
    set_cfg(100, 1, 63);
    for (int k = 0; k < 64; k++) send(1, 0, "R2 length clamped to 64");
    send(0, 0, "R2 oldest mark leaves at 64");

    // R1: extreme codes
    set_cfg(1, 8388608, 0);
    send(-2048, -2048, "R1 most negative qualifies");
    send(-2048, 2047, "R1 just below full scale");
    set_cfg(1, 16777215, 0);
    send(-2048, -2048, "R1 maximum threshold");

    // R6: change mid-stream restarts the window
    set_cfg(4, 50, 1);
    for (int k = 0; k < 4; k++) send(10, 0, "R6 before change");
    set_cfg(4, 50, 2);
    for (int k = 0; k < 4; k++) send(10, 0, "R6 refill after change");

    // Mixed pattern with gaps
    set_cfg(16, 40, 8);
    for (int k = 0; k < 60; k++) begin
      send(((k * 7) % 11) - 5, ((k * 3) % 9) - 4, "R3 mixed stream");
      if (k % 9 == 4) idle(2);
    end
    idle(3);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule